// File: doc/BRIEF.md
# Ordered Delay Link with Freshness-Tagged Holding Register

This block models a point-to-point link between two loosely clocked nodes. Each message sent by the producer enters an in-transit queue and waits there until the link reports an arrival event. On that event, the oldest waiting message moves into a one-place holding register, which the consumer can read on every cycle.

Every delivery flips a one-bit tag stored beside the held value. A consumer can therefore tell a new delivery from a stale one, even when the producer resends the same data. The arrival events stand in for the transmission delays, so a test environment can impose any delay pattern without changing the block.

The queue depth is a parameter. A message sent while the queue is full, and while no delivery frees a slot in the same cycle, is discarded and raises a sticky overflow flag.

Top module: `delay_link`

## Requirements
- R1: After reset, `held_data_o` equals the parameter `DEFAULT_DATA`, `held_tag_o` is 0, `occupancy_o` is 0 and `overflow_o` is 0.
- R2: A send with the queue not full and no arrival appends the message at the tail and raises `occupancy_o` by one after the next rising clock edge.
- R3: An arrival with a non-empty queue loads the head message into `held_data_o` after the next rising clock edge and removes it from the queue, lowering `occupancy_o` by one.
- R4: An arrival while the queue is empty is ignored: `held_data_o`, `held_tag_o` and `occupancy_o` keep their values (a send in the same cycle is still appended).
- R5: A send and an arrival in the same cycle with a non-empty queue deliver the head, remove it and append the new message in one step, leaving `occupancy_o` unchanged.
- R6: Messages are delivered in the order they were sent; none is delivered before an earlier one.
- R7: Between deliveries, `held_data_o` and `held_tag_o` stay at their last delivered values on every cycle.
- R8: `held_tag_o` becomes 1 on the first delivery after reset and inverts on each later delivery, including deliveries of identical data.
- R9: A send with `DEPTH` messages queued and no valid arrival in that cycle is dropped and sets `overflow_o`, which stays 1 until reset. A send into a full queue that coincides with a valid arrival is accepted.
- R10: `occupancy_o` never exceeds `DEPTH` and always equals the number of messages sent and accepted but not yet delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| send_i | input | 1 | Producer sends a message this cycle |
| send_data_i | input | DATA_W | Message payload |
| arrive_i | input | 1 | Arrival event: deliver the head message if one waits |
| held_data_o | output | DATA_W | Last delivered message, or the default value |
| held_tag_o | output | 1 | Freshness tag, inverted on each delivery |
| occupancy_o | output | $clog2(DEPTH+1) | Number of messages in transit |
| overflow_o | output | 1 | Sticky flag: a send was dropped into a full queue |

## Verification
In a single cycle a send can enqueue while an arrival dequeues, and this becomes a corner case when the queue is empty, holds one entry, or is full. The bench builds each of these states on purpose and then drives both strobes together. It also lets random send and arrival strobes, with a small data alphabet, hit the same overlap many times. The result is judged against a reference queue in the bench: the held value must be the old head, the tag must flip once, the occupancy must follow the accepted pushes and pops, and a full queue must accept the send only when a pop frees a slot.

// File: rtl/delay_link_pkg.sv
package delay_link_pkg;

  typedef enum logic [1:0] {
    FOP_IDLE = 2'b00,
    FOP_PUSH = 2'b01,
    FOP_POP  = 2'b10,
    FOP_BOTH = 2'b11
  } fifo_op_e;

  function automatic fifo_op_e fifo_op(input logic push, input logic pop);
    return fifo_op_e'({pop, push});
  endfunction

endpackage

// File: rtl/link_admit.sv
module link_admit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic send_i,
  input  logic arrive_i,
  input  logic empty_i,
  input  logic full_i,
  output logic push_o,
  output logic pop_o,
  output logic overflow_o
);

  logic ovf_q;

  // arrival only counts when something is in transit
  assign pop_o  = arrive_i && !empty_i;
  // a pop in the same cycle frees the slot for a push into a full queue
  assign push_o = send_i && (!full_i || pop_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ovf_q <= 1'b0;
    else if (send_i && full_i && !pop_o) ovf_q <= 1'b1;
  end

  assign overflow_o = ovf_q;

  // R9
  drop_sets_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && full_i && !arrive_i) |=> overflow_o);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

endmodule

// File: rtl/link_fifo.sv
module link_fifo
  import delay_link_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  count_o
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  fifo_op_e          op;

  assign op = fifo_op(push_i, pop_i);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      slot_q[i] <= '0;
      else if (push_i && (wr_ptr_q == PTR_W'(i)))       slot_q[i] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case (op)
        FOP_PUSH: count_q <= count_q + 1'b1;
        FOP_POP:  count_q <= count_q - 1'b1;
        default:  count_q <= count_q;
      endcase
    end
  end

  assign head_o  = slot_q[rd_ptr_q];
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == FULL_CNT);
  assign count_o = count_q;

  // R10
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);

  // R5
  both_keeps_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(count_q));

  // R4
  idle_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o);

endmodule

// File: rtl/link_hold.sv
module link_hold #(
  parameter int                DATA_W       = 8,
  parameter logic [DATA_W-1:0] DEFAULT_DATA = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              tag_o
);

  logic [DATA_W-1:0] data_q;
  logic              tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= DEFAULT_DATA;
      tag_q  <= 1'b0;
    end else if (load_i) begin
      data_q <= data_i;
      tag_q  <= !tag_q;
    end
  end

  assign data_o = data_q;
  assign tag_o  = tag_q;

  // R8
  tag_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (tag_o != $past(tag_o)));

  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(tag_o) && $stable(data_o)));

endmodule

// File: rtl/delay_link.sv
module delay_link #(
  parameter int                DATA_W       = 8,
  parameter int                DEPTH        = 4,
  parameter logic [DATA_W-1:0] DEFAULT_DATA = '0,
  localparam int               CNT_W        = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_i,
  input  logic [DATA_W-1:0] send_data_i,
  input  logic              arrive_i,
  output logic [DATA_W-1:0] held_data_o,
  output logic              held_tag_o,
  output logic [CNT_W-1:0]  occupancy_o,
  output logic              overflow_o
);

  logic              push, pop, empty, full;
  logic [DATA_W-1:0] head;

  link_admit u_admit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .send_i     (send_i),
    .arrive_i   (arrive_i),
    .empty_i    (empty),
    .full_i     (full),
    .push_o     (push),
    .pop_o      (pop),
    .overflow_o (overflow_o)
  );

  link_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (send_data_i),
    .head_o      (head),
    .empty_o     (empty),
    .full_o      (full),
    .count_o     (occupancy_o)
  );

  link_hold #(.DATA_W(DATA_W), .DEFAULT_DATA(DEFAULT_DATA)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pop),
    .data_i (head),
    .data_o (held_data_o),
    .tag_o  (held_tag_o)
  );

  // R4
  empty_arrival_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arrive_i && occupancy_o == '0) |=> ($stable(held_tag_o) && $stable(held_data_o)));

  // R3
  deliver_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arrive_i && occupancy_o != '0) |=> (held_data_o == $past(head)));

endmodule

// File: tb/delay_link_tb.sv
`timescale 1ns/1ps
module delay_link_tb;

  localparam int             DW    = 8;
  localparam int             DEPTH = 4;
  localparam int             CW    = $clog2(DEPTH + 1);
  localparam logic [DW-1:0]  DEF   = 8'hA5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          send = 1'b0;
  logic [DW-1:0] sdata = '0;
  logic          arrive = 1'b0;
  logic [DW-1:0] held_data;
  logic          held_tag;
  logic [CW-1:0] occ;
  logic          ovf;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mq[$];
  logic [DW-1:0] exp_data;
  logic          exp_tag;
  logic          exp_ovf;

  always #10 clk = ~clk;

  delay_link #(.DATA_W(DW), .DEPTH(DEPTH), .DEFAULT_DATA(DEF)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .send_i      (send),
    .send_data_i (sdata),
    .arrive_i    (arrive),
    .held_data_o (held_data),
    .held_tag_o  (held_tag),
    .occupancy_o (occ),
    .overflow_o  (ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    send = 1'b0; arrive = 1'b0; rst_n = 1'b0;
    mq.delete();
    exp_data = DEF; exp_tag = 1'b0; exp_ovf = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "data", int'(held_data), int'(DEF));
    chk("R1", "tag", int'(held_tag), 0);
    chk("R1", "occupancy", int'(occ), 0);
    chk("R1", "overflow", int'(ovf), 0);
  endtask

  // one cycle: drive at negedge, compare just after the next rising edge
  task automatic step(input logic s, input logic a, input logic [DW-1:0] d);
    logic  was_full, pop;
    string req;
    @(negedge clk);
    send = s; arrive = a; sdata = d;
    was_full = (mq.size() == DEPTH);
    pop = a && (mq.size() != 0);
    req = "R7";
    if (a && !pop) req = "R4";
    if (s && !a) req = "R2";
    if (pop) begin
      exp_data = mq.pop_front();
      exp_tag = ~exp_tag;
      req = s ? "R5" : "R3";
    end
    if (s) begin
      if (!was_full || pop) mq.push_back(d);
      else begin
        exp_ovf = 1'b1;
        req = "R9";
      end
    end
    @(posedge clk);
    #1;
    chk(pop ? "R6" : req, "data", int'(held_data), int'(exp_data));
    chk(pop ? "R8" : req, "tag", int'(held_tag), int'(exp_tag));
    chk(req, "occupancy", int'(occ), mq.size());
    chk("R9", "overflow", int'(ovf), int'(exp_ovf));
    chk("R10", "bound", int'(occ <= CW'(DEPTH)), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    do_reset();

    // R4: arrivals on an empty queue leave everything untouched
    step(1'b0, 1'b1, 8'h00);
    step(1'b0, 1'b1, 8'h00);
    // R4: send with arrival on empty queue: push only
    step(1'b1, 1'b1, 8'h11);
    step(1'b0, 1'b1, 8'h00);   // R3 deliver 0x11, tag 1
    // R8: identical values still flip the tag
    step(1'b1, 1'b0, 8'h5A);
    step(1'b1, 1'b0, 8'h5A);
    step(1'b1, 1'b0, 8'h5A);
    step(1'b0, 1'b1, 8'h00);
    step(1'b0, 1'b0, 8'h00);   // R7 hold
    step(1'b0, 1'b1, 8'h00);
    step(1'b0, 1'b1, 8'h00);
    // R5: one entry plus simultaneous send and arrive
    step(1'b1, 1'b0, 8'h21);
    step(1'b1, 1'b1, 8'h22);
    step(1'b1, 1'b1, 8'h23);
    step(1'b0, 1'b1, 8'h00);
    // R9: fill, full plus arrival accepted, then overflow
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 8'h30 + 8'(i));
    step(1'b1, 1'b1, 8'h3F);
    step(1'b1, 1'b0, 8'h40);
    step(1'b0, 1'b0, 8'h00);
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 8'h00);

    // R6: random traffic with duplicates against the reference queue
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom_range(0, 3)));
    end
    step(1'b0, 1'b0, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule